// File: doc/BRIEF.md
# Early-reset merged-capacitor SAR controller

This block sequences a synchronous successive-approximation conversion for a differential charge-redistribution converter. Its capacitors are switched in a merged scheme with early reset. A start pulse begins a conversion. The first comparator decision fixes the conversion polarity b1. Each later cycle drives the next capacitor to b1. The comparator result from that cycle then decides only whether the capacitor driven just before is pulled back to common-mode.

At the end every capacitor sits either at common-mode or at the b1 polarity. The controller maps this final state to an unsigned N-bit code, raises done for one cycle and holds the code. The capacitor array, the comparator and the sampling switch are outside the block. The comparator is sampled on every rising clock edge during a conversion.

The width N defaults to 10, and the array then has N-1 capacitors. Capacitor k has binary weight 2^k, so capacitor N-2 is the largest.

Top module: `mcap_sar_ctrl`

## Requirements
- R1: After reset, and whenever no conversion is running, every capacitor select is common-mode (00) and done_o is 0. code_o is 0 after reset.
- R2: Capacitor k is driven on cap_sel_o[2k+1:2k], where k runs from 0 to N-2 and capacitor N-2 has the largest weight. The encodings are 00 for common-mode, 01 for low and 10 for high. The value 11 never appears.
- R3: In the first cycle after start is accepted, all capacitors stay at common-mode. comp_i is sampled at the end of that cycle and gives b1. Capacitor N-2 is then driven high if b1 is 1 and low if b1 is 0.
- R4: In each later phase the next lower capacitor is driven to the b1 polarity, whatever comp_i is.
- R5: When the comp_i sampled with a capacitor freshly driven differs from b1, that capacitor returns to common-mode. When it equals b1, the capacitor keeps its setting. A capacitor never moves directly between high and low, and high and low are never present at the same time.
- R6: One further comparison follows the phase of capacitor 0. It resets capacitor 0 to common-mode if it differs from b1, and this happens before the code is formed.
- R7: code_o equals 2^(N-1), plus the sum of +2^k for each high capacitor and -2^k for each low capacitor, minus 1 when b1 is 0. With an ideal comparator this is floor(x)+2^(N-1) for an input x in DAC units. An all-common-mode result therefore gives 2^(N-1) or 2^(N-1)-1.
- R8: done_o is high for exactly one cycle, N+1 clock edges after the edge that accepts start. In that cycle all capacitors are back at common-mode.
- R9: A start pulse is ignored while a conversion runs, including its final fold cycle. A start pulse in the cycle where done_o is high is accepted.
- R10: code_o changes only when done_o rises, and holds its value through the following conversion until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled when idle |
| comp_i | input | 1 | Comparator decision, 1 when the input exceeds the DAC level |
| cap_sel_o | output | 2*(N-1) | Bottom-plate select per capacitor, 2 bits each |
| done_o | output | 1 | One-cycle end-of-conversion flag |
| code_o | output | N | Unsigned conversion result |

## Verification
Two events can fall in the same cycle: the done pulse of one conversion and the acceptance of the next start. The bench provokes this by raising start exactly in the done cycle. It then judges that the old code is presented and still held midway through the new conversion, and that the new conversion produces its own correct code. A second case sits one cycle earlier, in the fold cycle. There a start pulse must be lost, with no second done and the capacitors left at common-mode. An ideal charge model answers the comparator from the drive states, and every input level over the full range is converted back to back.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  typedef enum logic [1:0] {
    SEL_CM = 2'b00,
    SEL_LO = 2'b01,
    SEL_HI = 2'b10
  } cap_sel_e;
endpackage

// File: rtl/mcap_phase_seq.sv
module mcap_phase_seq #(
  parameter int N  = 10,
  parameter int PW = $clog2(N+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [PW-1:0] phase_o,
  output logic          fold_o
);
  localparam logic [PW-1:0] LAST_PH = PW'(N);

  logic          busy_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= '0;
      end
    end else if (phase_q == LAST_PH) begin
      busy_q <= 1'b0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = phase_q;
  assign fold_o  = busy_q && (phase_q == LAST_PH);
endmodule

// File: rtl/mcap_cap_bank.sv
module mcap_cap_bank import mcap_pkg::*; #(
  parameter int N    = 10,
  parameter int NCAP = N-1,
  parameter int PW   = $clog2(N+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              comp_i,
  input  logic              busy_i,
  input  logic [PW-1:0]     phase_i,
  input  logic              fold_i,
  output logic [2*NCAP-1:0] sel_o,
  output logic              b1_o
);
  logic b1_q;
  logic pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          b1_q <= 1'b0;
    else if (busy_i && phase_i == '0)     b1_q <= comp_i;
  end

  // phase 0 sets the top cap before b1 is registered
  assign pol  = (phase_i == '0) ? comp_i : b1_q;
  assign b1_o = b1_q;

  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    localparam logic [PW-1:0] SET_PH = PW'(NCAP-1-k);
    localparam logic [PW-1:0] CHK_PH = PW'(NCAP-k);
    cap_sel_e sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sel_q <= SEL_CM;
      else if (fold_i)
        sel_q <= SEL_CM;
      else if (busy_i && phase_i == SET_PH)
        sel_q <= pol ? SEL_HI : SEL_LO;
      else if (busy_i && phase_i == CHK_PH && comp_i != b1_q)
        sel_q <= SEL_CM;
    end

    assign sel_o[2*k +: 2] = sel_q;
  end
endmodule

// File: rtl/mcap_code_map.sv
module mcap_code_map import mcap_pkg::*; #(
  parameter int N    = 10,
  parameter int NCAP = N-1
) (
  input  logic [2*NCAP-1:0] sel_i,
  input  logic              b1_i,
  output logic [N-1:0]      code_o
);
  localparam int HALF = 1 << (N-1);

  int acc;

  always_comb begin
    acc = HALF - (b1_i ? 0 : 1);
    for (int k = 0; k < NCAP; k++) begin
      if (sel_i[2*k +: 2] == SEL_HI)      acc = acc + (1 << k);
      else if (sel_i[2*k +: 2] == SEL_LO) acc = acc - (1 << k);
    end
    code_o = acc[N-1:0];
  end
endmodule

// File: rtl/mcap_sar_ctrl.sv
module mcap_sar_ctrl #(
  parameter int N = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               comp_i,
  output logic [2*(N-1)-1:0] cap_sel_o,
  output logic               done_o,
  output logic [N-1:0]       code_o
);
  localparam int NCAP = N-1;
  localparam int PW   = $clog2(N+1);

  logic          busy;
  logic [PW-1:0] phase;
  logic          fold;
  logic          b1;
  logic [N-1:0]  code_w;
  logic [N-1:0]  code_q;
  logic          done_q;

  mcap_phase_seq #(.N(N), .PW(PW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy),
    .phase_o (phase),
    .fold_o  (fold)
  );

  mcap_cap_bank #(.N(N), .NCAP(NCAP), .PW(PW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .comp_i  (comp_i),
    .busy_i  (busy),
    .phase_i (phase),
    .fold_i  (fold),
    .sel_o   (cap_sel_o),
    .b1_o    (b1)
  );

  mcap_code_map #(.N(N), .NCAP(NCAP)) u_map (
    .sel_i  (cap_sel_o),
    .b1_i   (b1),
    .code_o (code_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fold;
      if (fold) code_q <= code_w;
    end
  end

  assign done_o = done_q;
  assign code_o = code_q;
endmodule

// File: rtl/mcap_sar_chk.sv
module mcap_sar_chk import mcap_pkg::*; #(
  parameter int N  = 10,
  parameter int PW = $clog2(N+1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy,
  input logic [PW-1:0]      phase,
  input logic               done_o,
  input logic [N-1:0]       code_o,
  input logic [2*(N-1)-1:0] cap_sel_o
);
  localparam int NCAP = N-1;

  logic has_hi, has_lo;

  always_comb begin
    has_hi = 1'b0;
    has_lo = 1'b0;
    for (int k = 0; k < NCAP; k++) begin
      if (cap_sel_o[2*k +: 2] == SEL_HI) has_hi = 1'b1;
      if (cap_sel_o[2*k +: 2] == SEL_LO) has_lo = 1'b1;
    end
  end

  AST_IDLE_ALL_CM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> cap_sel_o == '0); // R1

  AST_FIRST_PHASE_CM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && phase == '0) |-> cap_sel_o == '0); // R3

  AST_ONE_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(has_hi && has_lo)); // R5

  for (genvar k = 0; k < NCAP; k++) begin : g_cap_chk
    AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_sel_o[2*k +: 2] != 2'b11); // R2

    AST_NO_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_sel_o[2*k +: 2] != SEL_CM) |=>
        (cap_sel_o[2*k +: 2] == $past(cap_sel_o[2*k +: 2]) ||
         cap_sel_o[2*k +: 2] == SEL_CM)); // R5
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && phase != PW'(N)) |=> (busy && phase == $past(phase) + PW'(1))); // R9

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> done_o); // R10
endmodule

bind mcap_sar_ctrl mcap_sar_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy      (busy),
  .phase     (phase),
  .done_o    (done_o),
  .code_o    (code_o),
  .cap_sel_o (cap_sel_o)
);

// File: tb/tb_mcap_sar_ctrl.sv
module tb_mcap_sar_ctrl;
  localparam int N          = 10;
  localparam int NCAP       = N-1;
  localparam int HALF       = 1 << (N-1);
  localparam int CLK_PERIOD = 10;

  logic              clk_i   = 1'b0;
  logic              rst_ni  = 1'b0;
  logic              start_i = 1'b0;
  logic              comp_i;
  logic [2*NCAP-1:0] cap_sel_o;
  logic              done_o;
  logic [N-1:0]      code_o;

  int xh = 1;  // twice the analog input, always odd
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int dac_of(logic [2*NCAP-1:0] s);
    int a = 0;
    for (int k = 0; k < NCAP; k++) begin
      if (s[2*k +: 2] == 2'b10)      a += (1 << k);
      else if (s[2*k +: 2] == 2'b01) a -= (1 << k);
    end
    return a;
  endfunction

  // ideal charge model of the array and comparator
  always_comb comp_i = (xh > 2 * dac_of(cap_sel_o));

  mcap_sar_ctrl #(.N(N)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .comp_i    (comp_i),
    .cap_sel_o (cap_sel_o),
    .done_o    (done_o),
    .code_o    (code_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: legality every cycle, scoreboard on done
  always @(negedge clk_i) begin
    bit hi, lo, bad;
    int e;
    if (rst_ni && !finished) begin
      hi = 0; lo = 0; bad = 0;
      for (int k = 0; k < NCAP; k++) begin
        if (cap_sel_o[2*k +: 2] == 2'b11) bad = 1;
        if (cap_sel_o[2*k +: 2] == 2'b10) hi = 1;
        if (cap_sel_o[2*k +: 2] == 2'b01) lo = 1;
      end
      chk(!bad, "R2 select 11 driven", int'(bad), 0);
      chk(!(hi && lo), "R5 high and low together", int'(hi && lo), 0);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 done without accepted start", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(int'(code_o) == e, "R7 code", int'(code_o), e);
        end
      end
    end
  end

  task automatic start_conv(input int k);
    xh = 2*k + 1;
    exp_q.push_back(k + HALF);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // t = negedges already passed since the start negedge
  task automatic tail(input int t);
    repeat (N+1-t) @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done too early", int'(done_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b1, "R8 done timing", int'(done_o), 1);
    chk(cap_sel_o == '0, "R8 caps at CM on done", int'(cap_sel_o), 0);
  endtask

  task automatic conv(input int k);
    start_conv(k);
    tail(1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cap_sel_o == '0, "R1 reset caps", int'(cap_sel_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(code_o == '0, "R1 reset code", int'(code_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // traced conversion, x = 100.5
    start_conv(100);
    chk(cap_sel_o == '0, "R3 all CM before first decision", int'(cap_sel_o), 0);
    @(negedge clk_i);
    chk(cap_sel_o[17:16] == 2'b10, "R3 top cap high for b1=1", int'(cap_sel_o[17:16]), 2);
    @(negedge clk_i);
    chk(cap_sel_o[17:16] == 2'b00, "R5 top cap reset", int'(cap_sel_o[17:16]), 0);
    chk(cap_sel_o[15:14] == 2'b10, "R4 cap 7 driven to b1", int'(cap_sel_o[15:14]), 2);
    repeat (2) @(negedge clk_i);
    chk(cap_sel_o[13:12] == 2'b10, "R5 cap 6 kept", int'(cap_sel_o[13:12]), 2);
    chk(cap_sel_o[11:10] == 2'b10, "R4 cap 5 driven to b1", int'(cap_sel_o[11:10]), 2);
    tail(5);

    // negative polarity, x = -2.5
    start_conv(-3);
    @(negedge clk_i);
    chk(cap_sel_o[17:16] == 2'b01, "R3 top cap low for b1=0", int'(cap_sel_o[17:16]), 1);
    tail(2);

    // corners: all-CM results (last cap reset in fold, R6) and full scale
    conv(0);
    conv(-1);
    conv(-HALF);
    conv(HALF-1);

    // R9: starts mid-conversion and in the fold cycle are ignored
    start_conv(37);
    repeat (3) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (N-4) @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done early after ignored start", int'(done_o), 0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9 done timing unchanged", int'(done_o), 1);
    begin
      int extra = 0;
      repeat (N+3) begin
        @(negedge clk_i);
        if (done_o) extra++;
        chk(cap_sel_o == '0, "R9 caps stay CM after ignored start", int'(cap_sel_o), 0);
      end
      chk(extra == 0, "R9 extra done", extra, 0);
    end

    // R9/R10: start in the done cycle, old code held during new conversion
    conv(200);
    start_conv(-77);
    repeat (4) @(negedge clk_i);
    chk(int'(code_o) == 200 + HALF, "R10 code held", int'(code_o), 200 + HALF);
    tail(5);

    // full sweep, back to back
    for (int k = -HALF; k < HALF; k++) conv(k);

    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R8 missing done", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule